// File: doc/BRIEF.md
# Paged Memory Window Translator

This block sits on the socket side of a card controller and turns system memory cycles into card memory addresses. Software programs it through two byte-wide ports: a write to the index port selects a register and the data port then reads or writes that register. The block holds five independent windows. Each one claims a range of 4 KB system pages and relocates them onto card memory by adding a 14-bit page offset.

For every system memory cycle the translator reports, with no clock delay, whether a window claims the address and which one. It also gives the translated card address and the per-window cycle controls: attribute or common space, a 16-bit data path, zero-wait, a wait-state count of 0 to 3, and write protection. A write cycle that lands in a write-protected window is flagged so that the card strobe logic can suppress it. The optional page registers extend each window's match to system address bits 31 to 24.

Top module: `memwin_xlate`

## Requirements
- R1: After a synchronous active-low reset every register reads 0x00, the index port reads 0x00, and no cycle hits any window.
- R2: A write to the index port (host_port=0) stores the byte, which then reads back on the index port. Writes and reads on the data port (host_port=1) access the register at the stored index.
- R3: Indices outside the map read 0x00 and ignore writes. Unused bits 7..5 of the enable register at 0x06 also read 0. The map is: the enable register at 0x06; window w at 0x10+8w+k for k=0..5; and the page register of window w at 0x40+w.
- R4: Window w hits only when enable bit w of register 0x06 is set and the system page mem_addr[23:12] lies between the start and stop pages inclusive. The start page is {start_hi[3:0], start_lo} at k=1,0 and the stop page is {stop_hi[3:0], stop_lo} at k=3,2.
- R5: With page registers present, a window also requires mem_addr[31:24] to equal its page register at 0x40+w.
- R6: mem_card_addr = {(page + offset) mod 2^14, mem_addr[11:0]}. The offset is {off_hi[5:0], off_lo} at k=5,4.
- R7: The hitting window drives its controls onto the outputs: mem_wide from start_hi bit 7, mem_zero_wait from start_hi bit 6, mem_waits from stop_hi bits 7..6, mem_attr from off_hi bit 6 and mem_wprot from off_hi bit 7. All are 0 when nothing hits.
- R8: When several windows hit, the lowest-numbered one is reported on mem_win and supplies the translation.
- R9: mem_wr_block is 1 exactly for a write cycle (mem_write=1) that hits a write-protected window. A read of that window is not blocked.
- R10: Clearing a window's enable bit stops it hitting but leaves its bound, offset and page bytes intact. Setting the bit again restores the same mapping.
- R11: With mem_valid low no window hits and mem_wr_block stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per byte |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Index readback, or the register at the index |
| mem_valid | input | 1 | A system memory cycle is presented |
| mem_write | input | 1 | The cycle is a write |
| mem_addr | input | 32 | System byte address |
| mem_hit | output | 1 | Some enabled window claims the cycle |
| mem_win | output | 3 | Number of the winning window |
| mem_card_addr | output | 26 | Translated card byte address |
| mem_attr | output | 1 | 1 for attribute space, 0 for common |
| mem_wide | output | 1 | 16-bit data path requested |
| mem_zero_wait | output | 1 | Zero-wait cycle requested |
| mem_waits | output | 2 | Added wait states, 0 to 3 |
| mem_wprot | output | 1 | Winning window is write-protected |
| mem_wr_block | output | 1 | Write to a protected window, suppress it |

## Verification
The hardest states to reach are those where two enabled windows claim the same page, and where a single window's offset carries the card page past 2^14. Both need byte-level programming of several registers before the one probe that matters. The directed tasks build overlapping windows 1 and 3 and confirm that window 1 wins. They then disable window 1 and confirm that window 3 takes over. For the wrap, an offset of 0x3F00 is paired with system page 0x150, which carries out of the 14-bit card page field and must come back as card page 0x050.

// File: rtl/memwin_pkg.sv
// Package: shared constants and the decoded per-window configuration type
// for the paged memory window translator.
package memwin_pkg;
    localparam int PAGE_SHIFT  = 12;
    localparam int SYS_PAGE_W  = 12;
    localparam int CARD_PAGE_W = 14;
    localparam int GROUP_BYTES = 6;
    localparam int GROUP_STRIDE = 8;
    localparam logic [7:0] IDX_ENABLE   = 8'h06;
    localparam logic [7:0] IDX_WIN_BASE = 8'h10;
    localparam logic [7:0] IDX_PAGE_BASE = 8'h40;

    typedef struct packed {
        logic                   en;
        logic [SYS_PAGE_W-1:0]  start_pg;
        logic [SYS_PAGE_W-1:0]  stop_pg;
        logic [CARD_PAGE_W-1:0] offset;
        logic [7:0]             upper;
        logic                   wide;
        logic                   zero_wait;
        logic [1:0]             waits;
        logic                   attr;
        logic                   wprot;
    } win_cfg_t;
endpackage

// File: rtl/memwin_regfile.sv
// Module: memwin_regfile
// Holds the index register and every window byte behind an index/data port
// pair, and decodes the bytes into per-window configuration.
// Assumes NUM_WIN <= 5 so that the window groups stay below the page registers.
module memwin_regfile
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter bit PAGE_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic                   host_port,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    output logic [7:0]             cur_index,
    output win_cfg_t [NUM_WIN-1:0] cfg
);
    logic [7:0]         index_q;
    logic [NUM_WIN-1:0] en_q;
    logic [7:0]         grp_q  [NUM_WIN][GROUP_BYTES];
    logic [7:0]         page_q [NUM_WIN];
    logic [7:0]         data_rd;

    // Host writes: the index port, or the register that the index selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
            en_q    <= '0;
            for (int w = 0; w < NUM_WIN; w++) begin
                page_q[w] <= '0;
                for (int b = 0; b < GROUP_BYTES; b++) grp_q[w][b] <= '0;
            end
        end else if (host_we) begin
            if (!host_port) begin
                index_q <= host_wdata;
            end else begin
                if (index_q == IDX_ENABLE) en_q <= host_wdata[NUM_WIN-1:0];
                for (int w = 0; w < NUM_WIN; w++) begin
                    for (int b = 0; b < GROUP_BYTES; b++)
                        if (index_q == 8'(int'(IDX_WIN_BASE) + GROUP_STRIDE*w + b))
                            grp_q[w][b] <= host_wdata;
                    if (PAGE_EN && index_q == 8'(int'(IDX_PAGE_BASE) + w))
                        page_q[w] <= host_wdata;
                end
            end
        end
    end

    // Data-port read mux; unmapped indices fall through to zero.
    always_comb begin
        data_rd = '0;
        if (index_q == IDX_ENABLE) data_rd = 8'(en_q);
        for (int w = 0; w < NUM_WIN; w++) begin
            for (int b = 0; b < GROUP_BYTES; b++)
                if (index_q == 8'(int'(IDX_WIN_BASE) + GROUP_STRIDE*w + b))
                    data_rd = grp_q[w][b];
            if (PAGE_EN && index_q == 8'(int'(IDX_PAGE_BASE) + w))
                data_rd = page_q[w];
        end
    end

    assign host_rdata = host_port ? data_rd : index_q;
    assign cur_index  = index_q;

    // Byte-to-field decode of every window group.
    always_comb begin
        for (int w = 0; w < NUM_WIN; w++) begin
            cfg[w].en        = en_q[w];
            cfg[w].start_pg  = {grp_q[w][1][3:0], grp_q[w][0]};
            cfg[w].wide      = grp_q[w][1][7];
            cfg[w].zero_wait = grp_q[w][1][6];
            cfg[w].stop_pg   = {grp_q[w][3][3:0], grp_q[w][2]};
            cfg[w].waits     = grp_q[w][3][7:6];
            cfg[w].offset    = {grp_q[w][5][5:0], grp_q[w][4]};
            cfg[w].attr      = grp_q[w][5][6];
            cfg[w].wprot     = grp_q[w][5][7];
            cfg[w].upper     = PAGE_EN ? page_q[w] : 8'h00;
        end
    end
endmodule

// File: rtl/memwin_window.sv
// Module: memwin_window
// One window: compares the system page against inclusive bounds (and the
// upper address byte when page registers exist), and adds the card offset
// with wrap at 2^CARD_PAGE_W pages. Purely combinational.
module memwin_window
    import memwin_pkg::*;
#(
    parameter bit PAGE_EN = 1'b1
) (
    input  win_cfg_t               cfg,
    input  logic [SYS_PAGE_W-1:0]  sys_page,
    input  logic [7:0]             sys_upper,
    output logic                   hit,
    output logic [CARD_PAGE_W-1:0] card_page
);
    logic in_range;
    logic upper_ok;

    generate
        if (PAGE_EN) begin : g_upper
            assign upper_ok = (sys_upper == cfg.upper);
        end else begin : g_noupper
            logic unused_upper;
            assign unused_upper = ^sys_upper;
            assign upper_ok = 1'b1;
        end
    endgenerate

    // Inclusive page-bound compare and modulo offset add.
    always_comb begin
        in_range  = (sys_page >= cfg.start_pg) && (sys_page <= cfg.stop_pg);
        hit       = cfg.en && in_range && upper_ok;
        card_page = CARD_PAGE_W'(sys_page) + cfg.offset;
    end
endmodule

// File: rtl/memwin_prio.sv
// Module: memwin_prio
// Fixed-priority pick among window hits; the lowest index wins.
module memwin_prio #(
    parameter int N   = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] sel
);
    // Scan from the top down so the lowest requester is written last.
    always_comb begin
        any = |req;
        sel = '0;
        for (int i = N-1; i >= 0; i--)
            if (req[i]) sel = IDX_W'(i);
    end
endmodule

// File: rtl/memwin_xlate.sv
// Module: memwin_xlate (top)
// Paged memory window translator: register file, one translator per window,
// priority pick and output gating. Memory-side outputs follow the inputs
// combinationally; only host writes are clocked.
module memwin_xlate
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter bit PAGE_EN = 1'b1,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int CARD_AW   = CARD_PAGE_W + PAGE_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic                 host_port,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    input  logic                 mem_valid,
    input  logic                 mem_write,
    input  logic [31:0]          mem_addr,
    output logic                 mem_hit,
    output logic [WIN_IDX_W-1:0] mem_win,
    output logic [CARD_AW-1:0]   mem_card_addr,
    output logic                 mem_attr,
    output logic                 mem_wide,
    output logic                 mem_zero_wait,
    output logic [1:0]           mem_waits,
    output logic                 mem_wprot,
    output logic                 mem_wr_block
);
    win_cfg_t [NUM_WIN-1:0]   cfg;
    logic [7:0]               cur_index;
    logic [NUM_WIN-1:0]       win_hit;
    logic [CARD_PAGE_W-1:0]   win_page [NUM_WIN];
    logic                     any_hit;
    logic [WIN_IDX_W-1:0]     sel;
    win_cfg_t                 sel_cfg;

    memwin_regfile #(.NUM_WIN(NUM_WIN), .PAGE_EN(PAGE_EN)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_port(host_port),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cur_index(cur_index), .cfg(cfg)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            memwin_window #(.PAGE_EN(PAGE_EN)) u_win (
                .cfg(cfg[w]),
                .sys_page(mem_addr[PAGE_SHIFT+SYS_PAGE_W-1:PAGE_SHIFT]),
                .sys_upper(mem_addr[31:24]),
                .hit(win_hit[w]),
                .card_page(win_page[w])
            );
        end
    endgenerate

    memwin_prio #(.N(NUM_WIN), .IDX_W(WIN_IDX_W)) u_prio (
        .req(win_hit), .any(any_hit), .sel(sel)
    );

    // Output gating: everything is quiet unless a valid cycle hits.
    always_comb begin
        sel_cfg       = cfg[sel];
        mem_hit       = mem_valid && any_hit;
        mem_win       = mem_hit ? sel : '0;
        mem_card_addr = mem_hit ? {win_page[sel], mem_addr[PAGE_SHIFT-1:0]} : '0;
        mem_attr      = mem_hit && sel_cfg.attr;
        mem_wide      = mem_hit && sel_cfg.wide;
        mem_zero_wait = mem_hit && sel_cfg.zero_wait;
        mem_waits     = mem_hit ? sel_cfg.waits : 2'b00;
        mem_wprot     = mem_hit && sel_cfg.wprot;
        mem_wr_block  = mem_hit && sel_cfg.wprot && mem_write;
    end
endmodule

// File: rtl/memwin_checker.sv
// Module: memwin_checker
// Temporal checks on the translator's ports and index register, attached
// to every memwin_xlate instance by the bind below.
module memwin_checker #(
    parameter int NUM_WIN = 5,
    parameter int WIN_IDX_W = 3,
    parameter int CARD_AW = 26
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_we,
    input logic                 host_port,
    input logic [7:0]           host_wdata,
    input logic [7:0]           cur_index,
    input logic                 mem_valid,
    input logic                 mem_write,
    input logic [31:0]          mem_addr,
    input logic                 mem_hit,
    input logic [WIN_IDX_W-1:0] mem_win,
    input logic [CARD_AW-1:0]   mem_card_addr,
    input logic                 mem_wprot,
    input logic                 mem_wr_block
);
    // R1: reset returns the index register to zero.
    p_index_clear_r1: assert property (@(posedge clk)
        !rst_n |=> cur_index == 8'h00);

    // R2: an index-port write lands in the index register next cycle.
    p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && !host_port |=> cur_index == $past(host_wdata));

    // R6: the byte offset within a page passes through untouched.
    p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> mem_card_addr[11:0] == mem_addr[11:0]);

    // R8: the reported window always exists.
    p_win_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> int'(mem_win) < NUM_WIN);

    // R9: a block only for a write that hits a protected window.
    p_block_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_block |-> mem_hit && mem_write && mem_wprot);

    // R9: a protected write hit is always blocked.
    p_block_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit && mem_write && mem_wprot |-> mem_wr_block);

    // R11: no hit and no block without a valid cycle.
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> !mem_hit && !mem_wr_block);
endmodule

bind memwin_xlate memwin_checker #(
    .NUM_WIN(NUM_WIN), .WIN_IDX_W(WIN_IDX_W), .CARD_AW(CARD_AW)
) u_checker (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_port(host_port),
    .host_wdata(host_wdata), .cur_index(cur_index), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_hit(mem_hit),
    .mem_win(mem_win), .mem_card_addr(mem_card_addr), .mem_wprot(mem_wprot),
    .mem_wr_block(mem_wr_block)
);

// File: tb/tb_memwin_xlate.sv
// Directed bench for memwin_xlate: one task per scenario, each checking
// its own results against values computed from the requirements.
module tb_memwin_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_port = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        mem_valid = 1'b0;
    logic        mem_write = 1'b0;
    logic [31:0] mem_addr = '0;
    logic        mem_hit;
    logic [2:0]  mem_win;
    logic [25:0] mem_card_addr;
    logic        mem_attr, mem_wide, mem_zero_wait, mem_wprot, mem_wr_block;
    logic [1:0]  mem_waits;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    memwin_xlate dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_port(host_port),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_hit(mem_hit), .mem_win(mem_win), .mem_card_addr(mem_card_addr),
        .mem_attr(mem_attr), .mem_wide(mem_wide), .mem_zero_wait(mem_zero_wait),
        .mem_waits(mem_waits), .mem_wprot(mem_wprot), .mem_wr_block(mem_wr_block)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic host_put(input logic port, input logic [7:0] data);
        @(negedge clk);
        host_port = port; host_wdata = data; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] data);
        host_put(1'b0, idx);
        host_put(1'b1, data);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] data);
        host_put(1'b0, idx);
        host_port = 1'b1;
        #1 data = host_rdata;
    endtask

    task automatic prog_win(input int w, input logic [11:0] sp, input logic [11:0] ep,
                            input logic wide, input logic zw, input logic [1:0] wt,
                            input logic [13:0] off, input logic attr, input logic wp,
                            input logic [7:0] upper);
        logic [7:0] b;
        b = 8'h10 + 8'(8*w);
        reg_wr(b + 8'd0, sp[7:0]);
        reg_wr(b + 8'd1, {wide, zw, 2'b00, sp[11:8]});
        reg_wr(b + 8'd2, ep[7:0]);
        reg_wr(b + 8'd3, {wt, 2'b00, ep[11:8]});
        reg_wr(b + 8'd4, off[7:0]);
        reg_wr(b + 8'd5, {wp, attr, off[13:8]});
        reg_wr(8'h40 + 8'(w), upper);
    endtask

    task automatic probe(input logic [31:0] a, input logic wr);
        mem_addr = a; mem_write = wr; mem_valid = 1'b1;
        #1;
    endtask

    function automatic logic [25:0] exp_card(input logic [31:0] a, input logic [13:0] off);
        logic [13:0] pg;
        pg = 14'(a[23:12]) + off;
        return {pg, a[11:0]};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        check("R1", "index port", 32'(host_rdata), 0);
        reg_rd(8'h06, d); check("R1", "enable reg", 32'(d), 0);
        reg_rd(8'h15, d); check("R1", "win0 off_hi", 32'(d), 0);
        reg_rd(8'h44, d); check("R1", "page4", 32'(d), 0);
        probe(32'h0000_0000, 1'b0); check("R1", "no hit", 32'(mem_hit), 0);
        mem_valid = 1'b0;
    endtask

    task automatic t_access();
        logic [7:0] d;
        host_put(1'b0, 8'h2B);
        host_port = 1'b0; #1 check("R2", "index readback", 32'(host_rdata), 32'h2B);
        reg_wr(8'h2B, 8'h5A);
        reg_rd(8'h2B, d); check("R2", "data readback", 32'(d), 32'h5A);
        reg_wr(8'h2B, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        reg_wr(8'h07, 8'hFF); reg_rd(8'h07, d); check("R3", "idx 0x07", 32'(d), 0);
        reg_wr(8'h16, 8'hFF); reg_rd(8'h16, d); check("R3", "idx 0x16", 32'(d), 0);
        reg_wr(8'h37, 8'hFF); reg_rd(8'h37, d); check("R3", "idx 0x37", 32'(d), 0);
        reg_wr(8'h45, 8'hFF); reg_rd(8'h45, d); check("R3", "idx 0x45", 32'(d), 0);
        reg_wr(8'h90, 8'hFF); reg_rd(8'h90, d); check("R3", "idx 0x90", 32'(d), 0);
        reg_rd(8'h10, d); check("R3", "0x90 did not alias 0x10", 32'(d), 0);
        reg_wr(8'h06, 8'hE0); reg_rd(8'h06, d); check("R3", "enable bits 7..5", 32'(d), 0);
    endtask

    task automatic t_bounds();
        prog_win(2, 12'h100, 12'h1FF, 0, 0, 2'd0, 14'h0000, 0, 0, 8'h00);
        probe(32'h0010_0000, 0); check("R4", "disabled miss", 32'(mem_hit), 0);
        reg_wr(8'h06, 8'h04);
        probe(32'h0010_0000, 0); check("R4", "start page hit", 32'(mem_hit), 1);
        check("R4", "win id", 32'(mem_win), 2);
        probe(32'h001F_FFFF, 0); check("R4", "stop page hit", 32'(mem_hit), 1);
        probe(32'h000F_FFFF, 0); check("R4", "below start", 32'(mem_hit), 0);
        probe(32'h0020_0000, 0); check("R4", "above stop", 32'(mem_hit), 0);
    endtask

    task automatic t_page();
        reg_wr(8'h42, 8'h12);
        probe(32'h1215_0000, 0); check("R5", "upper match", 32'(mem_hit), 1);
        probe(32'h0015_0000, 0); check("R5", "upper 0x00", 32'(mem_hit), 0);
        probe(32'h1315_0000, 0); check("R5", "upper 0x13", 32'(mem_hit), 0);
        reg_wr(8'h42, 8'h00);
    endtask

    task automatic t_xlate();
        prog_win(0, 12'h150, 12'h15F, 0, 0, 2'd0, 14'h0010, 0, 0, 8'h00);
        reg_wr(8'h06, 8'h01);
        probe(32'h0015_1ABC, 0);
        check("R6", "plain add", 32'(mem_card_addr), 32'(exp_card(32'h0015_1ABC, 14'h0010)));
        reg_wr(8'h14, 8'h00); reg_wr(8'h15, 8'h3F);
        probe(32'h0015_0ABC, 0);
        check("R6", "wrap add", 32'(mem_card_addr), 32'h0050ABC);
    endtask

    task automatic t_attrs();
        prog_win(4, 12'h300, 12'h300, 1, 1, 2'd2, 14'h0000, 1, 0, 8'h00);
        reg_wr(8'h06, 8'h10);
        probe(32'h0030_0004, 0);
        check("R7", "wide", 32'(mem_wide), 1);
        check("R7", "zero wait", 32'(mem_zero_wait), 1);
        check("R7", "waits", 32'(mem_waits), 2);
        check("R7", "attr", 32'(mem_attr), 1);
        check("R7", "wprot", 32'(mem_wprot), 0);
        probe(32'h0030_1000, 0);
        check("R7", "quiet when miss", 32'({mem_wide, mem_zero_wait, mem_waits, mem_attr}), 0);
    endtask

    task automatic t_prio();
        prog_win(1, 12'h400, 12'h4FF, 0, 0, 2'd1, 14'h0001, 0, 0, 8'h00);
        prog_win(3, 12'h480, 12'h5FF, 0, 0, 2'd3, 14'h0002, 0, 0, 8'h00);
        reg_wr(8'h06, 8'h0A);
        probe(32'h0048_0123, 0);
        check("R8", "lowest wins", 32'(mem_win), 1);
        check("R8", "winner offset", 32'(mem_card_addr), 32'(exp_card(32'h0048_0123, 14'h0001)));
        check("R8", "winner waits", 32'(mem_waits), 1);
        reg_wr(8'h06, 8'h08);
        probe(32'h0048_0123, 0);
        check("R8", "fallback", 32'(mem_win), 3);
        check("R8", "fallback waits", 32'(mem_waits), 3);
    endtask

    task automatic t_wprot();
        prog_win(1, 12'h600, 12'h600, 0, 0, 2'd0, 14'h0000, 0, 1, 8'h00);
        reg_wr(8'h06, 8'h0A);
        probe(32'h0060_0010, 1); check("R9", "protected write", 32'(mem_wr_block), 1);
        probe(32'h0060_0010, 0); check("R9", "protected read", 32'(mem_wr_block), 0);
        check("R9", "read still hits", 32'(mem_hit), 1);
        probe(32'h0050_0010, 1); check("R9", "open write", 32'(mem_wr_block), 0);
    endtask

    task automatic t_retain();
        logic [7:0] d;
        reg_wr(8'h06, 8'h00);
        probe(32'h0060_0010, 0); check("R10", "disabled miss", 32'(mem_hit), 0);
        reg_rd(8'h18, d); check("R10", "start_lo kept", 32'(d), 32'h00);
        reg_rd(8'h19, d); check("R10", "start_hi kept", 32'(d), 32'h06);
        reg_rd(8'h1D, d); check("R10", "off_hi kept", 32'(d), 32'h80);
        reg_wr(8'h06, 8'h02);
        probe(32'h0060_0010, 0); check("R10", "re-enabled hit", 32'(mem_win), 1);
        check("R10", "re-enabled hit flag", 32'(mem_hit), 1);
    endtask

    task automatic t_idle();
        mem_addr = 32'h0060_0010; mem_write = 1'b1; mem_valid = 1'b0;
        #1;
        check("R11", "no hit", 32'(mem_hit), 0);
        check("R11", "no block", 32'(mem_wr_block), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_access();
        t_reserved();
        t_bounds();
        t_page();
        t_xlate();
        t_attrs();
        t_prio();
        t_wprot();
        t_retain();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule